// File: doc/BRIEF.md
# Handset Call State Controller

This block sits on the handset side of a simple telephone. It keeps track of the call state. Its inputs are single-cycle pulses: the handset being lifted or replaced, a digit being dialled (with a flag that marks the final digit), and an alert from the exchange that a call is coming in. From the state it drives a dial-tone enable and a ringer enable. Any event that the current state does not define is reported with a one-cycle flag, and the state does not change.

An internal down-counter limits how long the phone rings. An incoming alert loads it with `RING_TICKS`. Lifting the handset cancels it and clears it. When it reaches zero in the ringing state, the phone goes back to idle. The default length is twenty seconds at 100 MHz, and simulation can use a small value instead.

Top module: `call_ctrl`

## Requirements
- R1: After reset the state is idle (`call_state` = 0), and `dial_tone`, `ringer` and `unexpected_evt` are low.
- R2: In idle (0), `off_hook` moves the state to dialling (1) at the next edge. `dial_tone` is high exactly while the state is dialling.
- R3: In idle, `call_alert` moves the state to ringing (2) and loads the ring timer with `RING_TICKS`. `ringer` is high exactly while the state is ringing.
- R4: In ringing, `off_hook` moves the state to talking (3), turns the ringer off and clears the ring timer.
- R5: When an alert is not answered, the state stays ringing for `RING_TICKS`+1 cycles and then returns to idle by itself.
- R6: In dialling, `dial_digit` without `last_digit` keeps the state. `dial_digit` together with `last_digit` moves the state to talking.
- R7: `on_hook` in dialling or talking returns the state to idle.
- R8: An undefined event leaves the state unchanged and raises `unexpected_evt` for exactly the next cycle. The undefined events are: `on_hook` in idle or ringing, `off_hook` in dialling or talking, `call_alert` outside idle, and `dial_digit` outside dialling.
- R9: When several inputs pulse in the same cycle, only the highest-ranked one is acted on. The ranking, from highest to lowest, is `on_hook`, then `off_hook`, then `call_alert`, then `dial_digit`, then ring-timer expiry. Lower-ranked events in that cycle are dropped and are not flagged.
- R10: `last_digit` without `dial_digit` has no effect.
- R11: The ring timer is zero whenever the state is not ringing. Each new alert therefore rings for the full length, whatever happened to earlier calls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_hook | input | 1 | Handset lifted (pulse) |
| on_hook | input | 1 | Handset replaced (pulse) |
| dial_digit | input | 1 | A digit was dialled (pulse) |
| last_digit | input | 1 | Qualifies `dial_digit` as the final digit |
| call_alert | input | 1 | Incoming call from the exchange (pulse) |
| call_state | output | 2 | 0 idle, 1 dialling, 2 ringing, 3 talking |
| dial_tone | output | 1 | Dial-tone enable |
| ringer | output | 1 | Ringer enable |
| unexpected_evt | output | 1 | One-cycle flag for an undefined event |

## Verification
On every cycle, the assertions check the transitions for hang-up, answer and alert. They also check that a flagged event left the state unchanged and that the ring timer is zero outside ringing. Only the bench scenarios can show the full ringing duration and the return to idle after it. The same holds for the ranking of simultaneous events, the rule that a lone `last_digit` does nothing, and the full-length ringing after a cancelled call. The bench checks these with a reference model that it compares on every clock.

// File: rtl/call_ctrl.sv
module call_ctrl #(
  parameter int unsigned RING_TICKS = 2000000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       off_hook,
  input  logic       on_hook,
  input  logic       dial_digit,
  input  logic       last_digit,
  input  logic       call_alert,
  output logic [1:0] call_state,
  output logic       dial_tone,
  output logic       ringer,
  output logic       unexpected_evt
);
  localparam int TW = $clog2(RING_TICKS + 1);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DIAL = 2'd1, ST_RING = 2'd2, ST_TALK = 2'd3} st_t;

  st_t           st, st_nx;
  logic [TW-1:0] tmr, tmr_nx;
  logic          bad_nx, bad_q;

  wire expired = (st == ST_RING) && (tmr == '0);

  always_comb begin
    st_nx  = st;
    tmr_nx = (tmr != '0) ? tmr - 1'b1 : tmr;
    bad_nx = 1'b0;
    if (on_hook) begin
      if (st == ST_DIAL || st == ST_TALK) st_nx = ST_IDLE;
      else bad_nx = 1'b1;
    end else if (off_hook) begin
      if (st == ST_IDLE) st_nx = ST_DIAL;
      else if (st == ST_RING) begin
        st_nx  = ST_TALK;
        tmr_nx = '0;
      end else bad_nx = 1'b1;
    end else if (call_alert) begin
      if (st == ST_IDLE) begin
        st_nx  = ST_RING;
        tmr_nx = TW'(RING_TICKS);
      end else bad_nx = 1'b1;
    end else if (dial_digit) begin
      if (st == ST_DIAL) begin
        if (last_digit) st_nx = ST_TALK;
      end else bad_nx = 1'b1;
    end else if (expired) begin
      st_nx = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      tmr   <= '0;
      bad_q <= 1'b0;
    end else begin
      st    <= st_nx;
      tmr   <= tmr_nx;
      bad_q <= bad_nx;
    end
  end

  assign call_state     = st;
  assign dial_tone      = (st == ST_DIAL);
  assign ringer         = (st == ST_RING);
  assign unexpected_evt = bad_q;

  // R7
  hangup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (on_hook && (st == ST_DIAL || st == ST_TALK)) |=> (st == ST_IDLE));

  // R4
  answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_hook && off_hook && st == ST_RING) |=> (st == ST_TALK && tmr == '0 && !ringer));

  // R3
  alert_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_hook && !off_hook && call_alert && st == ST_IDLE) |=> (st == ST_RING && tmr == TW'(RING_TICKS)));

  // R8
  unexp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unexpected_evt |-> (st == $past(st)));

  // R11
  timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_RING) |-> (tmr == '0));
endmodule

// File: tb/sim_call_ctrl.sv
module sim_call_ctrl;
  localparam int unsigned TICKS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic off_hook = 0, on_hook = 0, dial_digit = 0, last_digit = 0, call_alert = 0;
  logic [1:0] call_state;
  logic dial_tone, ringer, unexpected_evt;

  int total = 0;
  int bad = 0;
  int m_st = 0;
  int m_tmr = 0;
  bit m_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  call_ctrl #(.RING_TICKS(TICKS)) u0 (
    .clk(clk), .rst_n(rst_n), .off_hook(off_hook), .on_hook(on_hook),
    .dial_digit(dial_digit), .last_digit(last_digit), .call_alert(call_alert),
    .call_state(call_state), .dial_tone(dial_tone), .ringer(ringer),
    .unexpected_evt(unexpected_evt)
  );

  task automatic compare(string tag);
    total++;
    if (call_state !== 2'(m_st) || dial_tone !== (m_st == 1) ||
        ringer !== (m_st == 2) || unexpected_evt !== m_bad) begin
      bad++;
      $display("FAIL %s: got st=%0d tone=%0b ring=%0b unexp=%0b, want st=%0d tone=%0b ring=%0b unexp=%0b",
               tag, call_state, dial_tone, ringer, unexpected_evt,
               m_st, (m_st == 1), (m_st == 2), m_bad);
    end
  endtask

  task automatic step(bit on, bit off, bit dig, bit last, bit alert, string tag);
    int ns;
    int nt;
    bit nb;
    @(negedge clk);
    on_hook = on; off_hook = off; dial_digit = dig; last_digit = last; call_alert = alert;
    ns = m_st;
    nt = (m_tmr > 0) ? m_tmr - 1 : 0;
    nb = 0;
    if (on) begin
      if (m_st == 1 || m_st == 3) ns = 0; else nb = 1;
    end else if (off) begin
      case (m_st)
        0: ns = 1;
        2: begin ns = 3; nt = 0; end
        default: nb = 1;
      endcase
    end else if (alert) begin
      if (m_st == 0) begin ns = 2; nt = TICKS; end else nb = 1;
    end else if (dig) begin
      if (m_st == 1) begin if (last) ns = 3; end else nb = 1;
    end else if (m_st == 2 && m_tmr == 0) begin
      ns = 0;
    end
    @(posedge clk);
    #1;
    m_st = ns; m_tmr = nt; m_bad = nb;
    compare(tag);
  endtask

  task automatic idle_n(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hung, want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    int ring_len;
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle_n(2, "R1 idle after reset");

    step(0, 1, 0, 0, 0, "R2 off-hook to dialling");
    step(0, 0, 1, 0, 0, "R6 digit keeps dialling");
    step(0, 0, 0, 1, 0, "R10 lone last_digit ignored");
    step(0, 0, 1, 1, 0, "R6 last digit to talking");
    step(0, 1, 0, 0, 0, "R8 off-hook in talking");
    idle_n(1, "R8 flag lasts one cycle");
    step(1, 0, 0, 0, 0, "R7 hang-up from talking");
    step(1, 0, 0, 0, 0, "R8 on-hook in idle");
    step(0, 0, 1, 0, 0, "R8 digit in idle");
    step(0, 1, 0, 0, 0, "R2 off-hook again");
    step(1, 0, 0, 0, 0, "R7 hang-up from dialling");

    step(0, 0, 0, 0, 1, "R3 alert to ringing");
    idle_n(2, "R3 ringing");
    step(0, 0, 1, 0, 0, "R8 digit in ringing");
    step(0, 0, 0, 0, 1, "R8 alert in ringing");
    step(0, 1, 0, 0, 0, "R4 answer");
    idle_n(TICKS + 2, "R11 no stale expiry in talking");
    step(1, 0, 0, 0, 0, "R7 hang-up");

    step(0, 0, 0, 0, 1, "R5 alert unanswered");
    ring_len = 1;
    for (int i = 0; i < TICKS + 4; i++) begin
      step(0, 0, 0, 0, 0, "R5 ring timeout");
      if (call_state == 2'd2) ring_len++;
    end
    total++;
    if (ring_len != TICKS + 1) begin
      bad++;
      $display("FAIL R5 ring length: got %0d want %0d", ring_len, TICKS + 1);
    end

    step(0, 1, 0, 0, 1, "R9 off-hook beats alert");
    step(1, 1, 0, 0, 0, "R9 on-hook beats off-hook");
    step(0, 0, 1, 1, 1, "R9 alert beats digit");
    idle_n(TICKS, "R9 wait to expiry");
    step(0, 1, 0, 0, 0, "R9 answer beats expiry");
    step(1, 0, 0, 0, 0, "R7 hang-up");

    step(0, 0, 0, 0, 1, "R11 alert after cancel");
    step(0, 1, 0, 0, 0, "R11 cancel");
    step(1, 0, 0, 0, 0, "R11 hang-up");
    step(0, 0, 0, 0, 1, "R11 new alert");
    idle_n(TICKS + 2, "R11 full length ring");

    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] & lfsr[1] & lfsr[2], lfsr[3] & lfsr[4], lfsr[5], lfsr[6],
           lfsr[7] & lfsr[2], "R9 mixed events");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule